// File: doc/BRIEF.md
# Banked GPIO Port Register File

A 24-pin general-purpose I/O port whose configuration and output levels are held in byte-wide registers on a simple synchronous bus. The pins form three 8-bit banks. Software chooses each pin's direction, drive type and pull, and reads back the pin levels. Output levels are never written directly. A set register raises selected output latches and a separate clear register lowers them, so two agents can update different pins without a read-modify-write.

For each pin, the block turns the direction, type, pull and output-latch bits into pad controls. These are output enable, output value, open-drain marker, pull-up, pull-down and analog mode. The type and pull bits mean different things for an input pin and for an output pin. Pad inputs pass through a synchronizer into a read-only state register.

Registers occupy groups of eight addresses: group g at address g*8, bank b at address g*8+b. Group 0 is pin state, group 1 is direction, group 2 is type, group 3 is pull, group 4 is set and group 5 is clear.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every direction, type, pull and output-latch bit is 0. Every pin therefore reads as an analog input: pad_oe, pad_pu, pad_pd, pad_od and pad_do are all 0 and pad_ana is all ones. Reads of the direction, type, pull and set addresses return 0x00.
- R2: Pin n is bit n%8 of bank n/8. Direction (0x08-0x0A, 0 = input, 1 = output), type (0x10-0x12) and pull (0x18-0x1A) are read/write and read back the value last written.
- R3: A write to 0x20+b sets the output-latch bits of bank b where the data bit is 1 and leaves the others unchanged. A read of 0x20+b or 0x28+b returns the latch of bank b.
- R4: A write to 0x28+b clears the output-latch bits of bank b where the data bit is 1 and leaves the others unchanged.
- R5: An output pin with type 0 is push-pull. pad_oe is 1 and pad_do equals the latch. pad_od, pad_pu, pad_pd and pad_ana are 0.
- R6: An output pin with type 1 is open-drain. pad_od is 1 and pad_do is 0. pad_oe is 1 only while the latch is 0. pad_pu equals the pull bit, and pad_pd and pad_ana are 0.
- R7: An input pin with type 1 has an internal pull. Pull bit 1 gives pad_pu = 1 and pad_pd = 0; pull bit 0 gives pad_pd = 1 and pad_pu = 0. pad_oe, pad_od and pad_ana are 0.
- R8: An input pin with type 0 uses no pull resistor. Pull bit 1 means floating, with every pad control 0. Pull bit 0 means analog, with pad_ana = 1 and all other controls 0.
- R9: pad_in passes through a two-flop synchronizer into the pin-state register, read at 0x00-0x02. A read whose capture edge is the first edge after a pad change still returns the old level. The state register is read-only, and writes to its addresses are ignored.
- R10: Reads of any other address return 0x00, including a bank index of 3 or more within a group and addresses 0x30 and above. Writes to those addresses change no register.
- R11: bus_rdata takes the addressed value on the clock edge where bus_rd is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 24 | Pad input levels |
| pad_oe | output | 24 | Pad output enable |
| pad_do | output | 24 | Pad output value |
| pad_od | output | 24 | Pin is configured open-drain |
| pad_pu | output | 24 | Enable pull-up |
| pad_pd | output | 24 | Enable pull-down |
| pad_ana | output | 24 | Analog mode (digital path off) |

## Verification
Every configuration bit reaches a pad control combinationally. A corrupted direction, type, pull or latch bit therefore shows on the pad outputs in the same cycle as the write that caused it, so the bench compares all six pad vectors after every write sweep. Bank mapping or set/clear masking errors appear as a wrong pin in those vectors, or as a wrong latch value read back through the set address one cycle later. A synchronizer with the wrong depth appears as a state read that changes one cycle too early or too late.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register groups, one per eight-address window
   typedef enum logic [2:0] {
      GRP_STATE = 3'd0,
      GRP_DIR   = 3'd1,
      GRP_TYPE  = 3'd2,
      GRP_PULL  = 3'd3,
      GRP_SET   = 3'd4,
      GRP_CLR   = 3'd5,
      GRP_NONE  = 3'd7
   } grp_e;

   // Per-pin pad control bundle
   typedef struct packed {
      logic oe;
      logic dout;
      logic od;
      logic pu;
      logic pd;
      logic ana;
   } pad_ctl_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int GRP_SHIFT = 3,
   parameter int NUM_BANKS = 3
) (
   input  logic [ADDR_W-1:0]    addr,
   output grp_e                 grp,
   output logic [GRP_SHIFT-1:0] bank
);
   localparam int UP_W = ADDR_W - GRP_SHIFT;

   if (UP_W < 3) begin : g_bad_addr_w
      $error("address too narrow for six register groups");
   end

   logic [UP_W-1:0] upper;

   assign upper = addr[ADDR_W-1:GRP_SHIFT];
   assign bank  = addr[GRP_SHIFT-1:0];

   always_comb begin
      grp = GRP_NONE;
      if (int'(bank) < NUM_BANKS) begin
         case (upper)
            UP_W'(0): grp = GRP_STATE;
            UP_W'(1): grp = GRP_DIR;
            UP_W'(2): grp = GRP_TYPE;
            UP_W'(3): grp = GRP_PULL;
            UP_W'(4): grp = GRP_SET;
            UP_W'(5): grp = GRP_CLR;
            default:  grp = GRP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dir,
   input  logic              wr_type,
   input  logic              wr_pull,
   input  logic              wr_set,
   input  logic              wr_clr,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] dir_q,
   output logic [BANK_W-1:0] type_q,
   output logic [BANK_W-1:0] pull_q,
   output logic [BANK_W-1:0] latch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         type_q  <= '0;
         pull_q  <= '0;
         latch_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= wdata;
         if (wr_type) type_q <= wdata;
         if (wr_pull) pull_q <= wdata;
         if (wr_set)
            latch_q <= latch_q | wdata;
         else if (wr_clr)
            latch_q <= latch_q & ~wdata;
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 24,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("synchronizer needs at least two stages");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
   import gpio_port_pkg::*;
(
   input  logic     is_out,
   input  logic     typ,
   input  logic     pull,
   input  logic     latch,
   output pad_ctl_t ctl
);
   always_comb begin
      ctl = '0;
      unique case ({is_out, typ})
         2'b10: begin            // push-pull output
            ctl.oe   = 1'b1;
            ctl.dout = latch;
         end
         2'b11: begin            // open-drain output
            ctl.od = 1'b1;
            ctl.oe = ~latch;
            ctl.pu = pull;
         end
         2'b01: begin            // input with pull
            ctl.pu = pull;
            ctl.pd = ~pull;
         end
         default: begin          // floating or analog input
            ctl.ana = ~pull;
         end
      endcase
   end
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS   = 3,
   parameter int BANK_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int GRP_SHIFT   = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_PINS   = NUM_BANKS * BANK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BANK_W-1:0]   bus_wdata,
   input  logic                bus_wr,
   input  logic                bus_rd,
   output logic [BANK_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_do,
   output logic [NUM_PINS-1:0] pad_od,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd,
   output logic [NUM_PINS-1:0] pad_ana
);
   if (NUM_BANKS < 1 || NUM_BANKS > (1 << GRP_SHIFT)) begin : g_bad_banks
      $error("bank count must fit in one address group");
   end
   if (BANK_W < 1) begin : g_bad_width
      $error("bank width must be positive");
   end

   grp_e                 grp;
   logic [GRP_SHIFT-1:0] bank_idx;

   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] type_q;
   logic [NUM_PINS-1:0] pull_q;
   logic [NUM_PINS-1:0] out_latch_q;
   logic [NUM_PINS-1:0] state_q;

   logic [BANK_W-1:0] rd_mux;
   logic [BANK_W-1:0] rdata_q;

   gpio_addr_decode #(
      .ADDR_W   (ADDR_W),
      .GRP_SHIFT(GRP_SHIFT),
      .NUM_BANKS(NUM_BANKS)
   ) u_decode (
      .addr(bus_addr),
      .grp (grp),
      .bank(bank_idx)
   );

   gpio_in_sync #(
      .W     (NUM_PINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (state_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = bus_wr && (bank_idx == GRP_SHIFT'(b));

      gpio_bank_regs #(
         .BANK_W(BANK_W)
      ) u_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_dir (bank_wr && grp == GRP_DIR),
         .wr_type(bank_wr && grp == GRP_TYPE),
         .wr_pull(bank_wr && grp == GRP_PULL),
         .wr_set (bank_wr && grp == GRP_SET),
         .wr_clr (bank_wr && grp == GRP_CLR),
         .wdata  (bus_wdata),
         .dir_q  (dir_q[b*BANK_W +: BANK_W]),
         .type_q (type_q[b*BANK_W +: BANK_W]),
         .pull_q (pull_q[b*BANK_W +: BANK_W]),
         .latch_q(out_latch_q[b*BANK_W +: BANK_W])
      );
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      pad_ctl_t ctl;

      gpio_pad_cell u_cell (
         .is_out(dir_q[n]),
         .typ   (type_q[n]),
         .pull  (pull_q[n]),
         .latch (out_latch_q[n]),
         .ctl   (ctl)
      );

      assign pad_oe[n]  = ctl.oe;
      assign pad_do[n]  = ctl.dout;
      assign pad_od[n]  = ctl.od;
      assign pad_pu[n]  = ctl.pu;
      assign pad_pd[n]  = ctl.pd;
      assign pad_ana[n] = ctl.ana;
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (int'(bank_idx) == b) begin
            case (grp)
               GRP_STATE:        rd_mux = state_q[b*BANK_W +: BANK_W];
               GRP_DIR:          rd_mux = dir_q[b*BANK_W +: BANK_W];
               GRP_TYPE:         rd_mux = type_q[b*BANK_W +: BANK_W];
               GRP_PULL:         rd_mux = pull_q[b*BANK_W +: BANK_W];
               GRP_SET, GRP_CLR: rd_mux = out_latch_q[b*BANK_W +: BANK_W];
               default:          rd_mux = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd)
         rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
   parameter int NUM_PINS = 24,
   parameter int BANK_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int SET_ADDR = 32,
   parameter int CLR_ADDR = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BANK_W-1:0]   bus_wdata,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [BANK_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] out_latch,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_do,
   input logic [NUM_PINS-1:0] pad_od,
   input logic [NUM_PINS-1:0] pad_pu,
   input logic [NUM_PINS-1:0] pad_pd,
   input logic [NUM_PINS-1:0] pad_ana
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_ana == '1 && pad_pu == '0 && pad_pd == '0));

   p_set_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(SET_ADDR)) |=>
         (out_latch[BANK_W-1:0] ==
          ($past(out_latch[BANK_W-1:0]) | $past(bus_wdata))));

   p_clr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CLR_ADDR)) |=>
         (out_latch[BANK_W-1:0] ==
          ($past(out_latch[BANK_W-1:0]) & ~$past(bus_wdata))));

   p_od_never_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & pad_oe & pad_do) == '0);

   p_pull_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0);

   p_analog_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_ana & (pad_oe | pad_pu | pad_pd | pad_od)) == '0);

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank_port gpio_port_checker #(
   .NUM_PINS(NUM_PINS),
   .BANK_W  (BANK_W),
   .ADDR_W  (ADDR_W),
   .SET_ADDR(4 << GRP_SHIFT),
   .CLR_ADDR(5 << GRP_SHIFT)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .out_latch(out_latch_q),
   .pad_oe   (pad_oe),
   .pad_do   (pad_do),
   .pad_od   (pad_od),
   .pad_pu   (pad_pu),
   .pad_pd   (pad_pd),
   .pad_ana  (pad_ana)
);

// File: tb/test_gpio_bank_port.sv
`timescale 1ns/1ps
module test_gpio_bank_port;
   localparam int NB = 3;
   localparam int NP = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_oe, pad_do, pad_od, pad_pu, pad_pd, pad_ana;

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0] m_dir [NB];
   logic [7:0] m_typ [NB];
   logic [7:0] m_pul [NB];
   logic [7:0] m_lat [NB];

   always #2.5 clk = ~clk;

   gpio_bank_port i_gpio_bank_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_do(pad_do), .pad_od(pad_od), .pad_pu(pad_pu),
      .pad_pd(pad_pd), .pad_ana(pad_ana)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   // Compare all pads against the model built from the requirements
   task automatic chk_pads(input string req);
      logic [NP-1:0] e_oe, e_do, e_od, e_pu, e_pd, e_an;
      for (int n = 0; n < NP; n++) begin
         logic d, t, p, l;
         d = m_dir[n/8][n%8]; t = m_typ[n/8][n%8];
         p = m_pul[n/8][n%8]; l = m_lat[n/8][n%8];
         e_oe[n] = d & (t ? ~l : 1'b1);
         e_do[n] = d & ~t & l;
         e_od[n] = d & t;
         e_pu[n] = t & p;
         e_pd[n] = ~d & t & ~p;
         e_an[n] = ~d & ~t & ~p;
      end
      chk({req, " pad_oe"},  32'(pad_oe),  32'(e_oe));
      chk({req, " pad_do"},  32'(pad_do),  32'(e_do));
      chk({req, " pad_od"},  32'(pad_od),  32'(e_od));
      chk({req, " pad_pu"},  32'(pad_pu),  32'(e_pu));
      chk({req, " pad_pd"},  32'(pad_pd),  32'(e_pd));
      chk({req, " pad_ana"}, 32'(pad_ana), 32'(e_an));
   endtask

   task automatic readback_all(input string req);
      logic [7:0] v;
      for (int b = 0; b < NB; b++) begin
         rd(8'(8 + b), v);  chk({req, " dir"},   32'(v), 32'(m_dir[b]));
         rd(8'(16 + b), v); chk({req, " type"},  32'(v), 32'(m_typ[b]));
         rd(8'(24 + b), v); chk({req, " pull"},  32'(v), 32'(m_pul[b]));
         rd(8'(32 + b), v); chk({req, " latch"}, 32'(v), 32'(m_lat[b]));
      end
   endtask

   function automatic logic [15:0] lfsr(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  v, v2;
      logic [15:0] seed;
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = '0; m_typ[b] = '0; m_pul[b] = '0; m_lat[b] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk_pads("R1 reset");
      readback_all("R1 reset");

      // R2: distinct per-bank values expose the bank/bit mapping
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = 8'h35 + 8'(b * 8'h41);
         wr(8'(8 + b), m_dir[b]);
      end
      chk("R2 mapping oe", 32'(pad_oe), 32'({m_dir[2], m_dir[1], m_dir[0]}));
      readback_all("R2 mapping");

      // R5 R6 R7 R8: every combination of dir/type/pull/latch on all pins
      for (int c = 0; c < 16; c++) begin
         for (int b = 0; b < NB; b++) begin
            m_dir[b] = c[0] ? 8'hFF : 8'h00;
            m_typ[b] = c[1] ? 8'hFF : 8'h00;
            m_pul[b] = c[2] ? 8'hFF : 8'h00;
            m_lat[b] = c[3] ? 8'hFF : 8'h00;
            wr(8'(8 + b),  m_dir[b]);
            wr(8'(16 + b), m_typ[b]);
            wr(8'(24 + b), m_pul[b]);
            if (c[3]) wr(8'(32 + b), 8'hFF); else wr(8'(40 + b), 8'hFF);
         end
         chk_pads("R5 R6 R7 R8 sweep");
      end

      // R2 R3 R4 R5 R6 R7 R8: mixed per-pin patterns
      seed = 16'hACE1;
      for (int it = 0; it < 30; it++) begin
         for (int b = 0; b < NB; b++) begin
            logic [7:0] s, k;
            seed = lfsr(seed); m_dir[b] = seed[7:0];  wr(8'(8 + b),  m_dir[b]);
            seed = lfsr(seed); m_typ[b] = seed[8:1];  wr(8'(16 + b), m_typ[b]);
            seed = lfsr(seed); m_pul[b] = seed[9:2];  wr(8'(24 + b), m_pul[b]);
            seed = lfsr(seed); s = seed[10:3];        wr(8'(32 + b), s);
            m_lat[b] = m_lat[b] | s;
            seed = lfsr(seed); k = seed[6:0] & 8'h7F; wr(8'(40 + b), k);
            m_lat[b] = m_lat[b] & ~k;
         end
         chk_pads("R3 R4 R5 R6 R7 R8 mixed");
      end
      readback_all("R2 R3 R4 mixed");

      // R3 R4: all-zero set and clear leave the latch untouched
      wr(8'h21, 8'h00);
      wr(8'h29, 8'h00);
      rd(8'h29, v);
      chk("R3 R4 zero data", 32'(v), 32'(m_lat[1]));
      chk_pads("R3 R4 zero data");

      // R9: synchronizer latency and read-only state
      pad_in = 24'h00A5C3;
      rd(8'h00, v);
      chk("R9 sync first edge old", 32'(v), 32'h00);
      repeat (2) @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         rd(8'(b), v);
         chk("R9 state", 32'(v), 32'(pad_in[b*8 +: 8]));
      end
      pad_in = 24'h5A3C96;
      repeat (3) @(negedge clk);
      wr(8'h02, 8'hFF);
      rd(8'h02, v);
      chk("R9 state write ignored", 32'(v), 32'h5A);
      rd(8'h01, v);
      chk("R9 state bank1", 32'(v), 32'h3C);

      // R10: unmapped reads and writes
      rd(8'h03, v); chk("R10 read 0x03", 32'(v), 32'h00);
      rd(8'h07, v); chk("R10 read 0x07", 32'(v), 32'h00);
      rd(8'h1B, v); chk("R10 read 0x1B", 32'(v), 32'h00);
      rd(8'h30, v); chk("R10 read 0x30", 32'(v), 32'h00);
      rd(8'hFF, v); chk("R10 read 0xFF", 32'(v), 32'h00);
      wr(8'h0B, 8'hFF); wr(8'h13, 8'hFF); wr(8'h1B, 8'hFF);
      wr(8'h23, 8'hFF); wr(8'h2B, 8'hFF); wr(8'h30, 8'hFF);
      wr(8'h88, 8'hFF); wr(8'hE0, 8'hFF);
      chk_pads("R10 writes ignored");
      readback_all("R10 writes ignored");

      // R11: read data holds while no read is issued
      rd(8'h10, v);
      m_typ[0] = ~v;
      wr(8'h10, m_typ[0]);
      repeat (3) @(negedge clk);
      chk("R11 hold", 32'(bus_rdata), 32'(v));
      rd(8'h10, v2);
      chk("R11 new read", 32'(v2), 32'(m_typ[0]));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule